// File: doc/BRIEF.md
# Windowed Watchdog Timer with One-Time Configuration

This block is a watchdog for a processor subsystem. A 12-bit down-counter advances on a slow tick enable, nominally 256 Hz, supplied from outside. Software must restart the counter through a keyed write to the control word. The restart is accepted only inside a window: the counter value must have fallen to the window delta or below. A restart that arrives while the counter is still above the delta counts as a fault, and so does letting the counter run out.

A fault always sets a status bit. It can also hold an interrupt line high, send a one-cycle reset request to the whole system or to the processor only, or do both. The mode word sets the reload value, the window delta, the fault routing, a disable bit and two halt bits. The halt bits freeze counting while an idle or debug input is high. The mode word takes only the first write after reset. Once it is locked, software has no way to stop or retune the watchdog.

The bus is a single-cycle register port with three word addresses. Read data appears one cycle after the read strobe.

Top module: `wwdt_top`

## Requirements
- R1: After reset the mode word reads 0x3FFF2FFF. This sets reload = 0xFFF in bits 11:0 and delta = 0xFFF in bits 27:16, with reset enable (bit 13), debug halt (bit 28) and idle halt (bit 29) set. The status reads 0, and irq and both reset requests are low.
- R2: Word address 0 is the control word, 1 is the mode word and 2 is the status word. `rdata` shows the addressed word in the cycle after `rd_en`. The control word reads as zero.
- R3: The mode word accepts only its first write after reset. Every later write to it is ignored, and the word keeps reading back the first value.
- R4: The mode bits are: interrupt enable bit 12, reset enable bit 13, processor-only reset bit 14, disable bit 15, debug halt bit 28, idle halt bit 29. The accepted mode write also reloads the counter with its new reload field.
- R5: Each tick decrements the counter. A tick that finds the counter at zero is an underflow fault: it sets status bit 0 and reloads the counter, which then keeps running. Without a restart, a fault therefore comes reload+1 ticks after a reload.
- R6: A control write with 0xA5 in bits 31:24 and bit 0 set is a restart. When the counter is at or below the delta, the restart reloads the counter and raises no fault. A control write with any other key is ignored.
- R7: A restart while the counter is above the delta is a window fault. It sets status bit 1 and reloads the counter.
- R8: With the disable bit set, the counter does not move, restarts are ignored and no fault is raised.
- R9: With idle halt set, the counter is frozen while `idle_in` is high. With debug halt set, the counter is frozen while `debug_in` is high. An input whose halt bit is clear does not freeze the counter.
- R10: Reading the status word clears both status bits. A fault in the same cycle as the read stays set.
- R11: `irq` is high while interrupt enable is set and either status bit is set.
- R12: With reset enable set, each fault gives a one-cycle pulse. The pulse goes to `sys_rst_req` when processor-only reset is clear and to `cpu_rst_req` when it is set. With reset enable clear, neither pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Slow counting tick, one cycle wide |
| idle_in | input | 1 | Processor idle indication |
| debug_in | input | 1 | Debugger halt indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Fault interrupt, level |
| sys_rst_req | output | 1 | System reset request pulse |
| cpu_rst_req | output | 1 | Processor-only reset request pulse |

## Verification
The counter cannot be read over the bus, so a wrong count shows up only as fault timing. A counter that is off by one, or that fails to freeze or reload, moves the underflow by at least one tick. The bench therefore places its status reads and pulse counts on the exact tick where the fault must and must not appear. A wrong window compare or a bad lock flag shows up at once: the status read right after a restart gives a wrong value, or the mode read-back after a second write does.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int REG_W       = 32;
  localparam int CNT_W       = 12;
  localparam int VAL_LSB     = 0;
  localparam int DLT_LSB     = 16;
  localparam int IEN_BIT     = 12;
  localparam int RSTEN_BIT   = 13;
  localparam int CPU_BIT     = 14;
  localparam int DIS_BIT     = 15;
  localparam int DBG_BIT     = 28;
  localparam int IDLE_BIT    = 29;
  localparam int KEY_LSB     = 24;
  localparam int KEY_W       = 8;
  localparam int RESTART_BIT = 0;
  localparam int ADDR_W      = 2;
  localparam int ST_W        = 2;
  localparam int ST_UF       = 0;
  localparam int ST_WIN      = 1;
  localparam logic [REG_W-1:0]  MODE_RST = 32'h3FFF_2FFF;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd2;
endpackage

// File: rtl/wwdt_cfg.sv
module wwdt_cfg
  import wwdt_pkg::*;
#(
  parameter int W   = REG_W,
  parameter int CW  = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  mode_q,
  output logic          commit,
  output logic [CW-1:0] commit_val,
  output logic [CW-1:0] reload,
  output logic [CW-1:0] delta,
  output logic          ien,
  output logic          rsten,
  output logic          cpu_only,
  output logic          dis,
  output logic          dbg_halt,
  output logic          idle_halt
);
  logic lock_q;

  assign commit     = we & ~lock_q;
  assign commit_val = wdata[VAL_LSB +: CW];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RST;
      lock_q <= 1'b0;
    end else if (commit) begin
      mode_q <= wdata;
      lock_q <= 1'b1;
    end
  end

  assign reload    = mode_q[VAL_LSB +: CW];
  assign delta     = mode_q[DLT_LSB +: CW];
  assign ien       = mode_q[IEN_BIT];
  assign rsten     = mode_q[RSTEN_BIT];
  assign cpu_only  = mode_q[CPU_BIT];
  assign dis       = mode_q[DIS_BIT];
  assign dbg_halt  = mode_q[DBG_BIT];
  assign idle_halt = mode_q[IDLE_BIT];

  // R3
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q && we) |=> $stable(mode_q));
endmodule

// File: rtl/wwdt_count.sv
module wwdt_count
  import wwdt_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          idle_in,
  input  logic          debug_in,
  input  logic          restart_req,
  input  logic          commit,
  input  logic [CW-1:0] commit_val,
  input  logic [CW-1:0] reload,
  input  logic [CW-1:0] delta,
  input  logic          dis,
  input  logic          dbg_halt,
  input  logic          idle_halt,
  output logic          uf_fault,
  output logic          win_fault
);
  localparam logic [CW-1:0] CNT_RST = MODE_RST[VAL_LSB +: CW];

  logic [CW-1:0] cnt_q;
  logic          frozen, restart_ok, step;

  assign frozen     = (idle_halt & idle_in) | (dbg_halt & debug_in);
  assign restart_ok = restart_req & ~dis;
  assign step       = tick_en & ~dis & ~frozen & ~restart_ok & ~commit;
  assign win_fault  = restart_ok & (cnt_q > delta);
  assign uf_fault   = step & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= CNT_RST;
    else if (commit)       cnt_q <= commit_val;
    else if (restart_ok)   cnt_q <= reload;
    else if (step) begin
      if (cnt_q == '0)     cnt_q <= reload;
      else                 cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (frozen && !restart_ok && !commit) |=> $stable(cnt_q));
  // R8
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (dis && !commit) |=> $stable(cnt_q));
  // R7
  win_reload_chk: assert property (@(posedge clk) disable iff (rst)
    win_fault |=> (cnt_q == $past(reload)));
  // R5
  uf_reload_chk: assert property (@(posedge clk) disable iff (rst)
    uf_fault |=> (cnt_q == $past(reload)));
endmodule

// File: rtl/wwdt_fault.sv
module wwdt_fault
  import wwdt_pkg::*;
#(
  parameter int SW = ST_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          uf_fault,
  input  logic          win_fault,
  input  logic          rd_clear,
  input  logic          ien,
  input  logic          rsten,
  input  logic          cpu_only,
  output logic [SW-1:0] status_q,
  output logic          irq_q,
  output logic          sys_q,
  output logic          cpu_q
);
  logic [SW-1:0] events, status_d;
  logic          any_fault;

  always_comb begin
    events         = '0;
    events[ST_UF]  = uf_fault;
    events[ST_WIN] = win_fault;
  end

  assign any_fault = |events;
  assign status_d  = (rd_clear ? '0 : status_q) | events;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
      sys_q    <= 1'b0;
      cpu_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= ien & (|status_d);
      sys_q    <= any_fault & rsten & ~cpu_only;
      cpu_q    <= any_fault & rsten & cpu_only;
    end
  end

  // R12
  sys_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sys_q |=> !sys_q);
  // R12
  cpu_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_q |=> !cpu_q);
  // R12
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    !(sys_q && cpu_q));
  // R10
  fault_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    uf_fault |=> status_q[ST_UF]);
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int                CW      = CNT_W,
  parameter logic [KEY_W-1:0]  KEY_VAL = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              idle_in,
  input  logic              debug_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq,
  output logic              sys_rst_req,
  output logic              cpu_rst_req
);
  logic [REG_W-1:0] mode_q;
  logic             mode_we, commit, restart_req, rd_clear;
  logic [CW-1:0]    commit_val, reload, delta;
  logic             ien, rsten, cpu_only, dis, dbg_halt, idle_halt;
  logic             uf_fault, win_fault;
  logic [ST_W-1:0]  status_q;

  assign mode_we     = wr_en & (addr == ADR_MODE);
  assign restart_req = wr_en & (addr == ADR_CTRL)
                     & (wdata[KEY_LSB +: KEY_W] == KEY_VAL)
                     & wdata[RESTART_BIT];
  assign rd_clear    = rd_en & (addr == ADR_STAT);

  wwdt_cfg #(.W(REG_W), .CW(CW)) u_cfg (
    .clk(clk), .rst(rst), .we(mode_we), .wdata(wdata),
    .mode_q(mode_q), .commit(commit), .commit_val(commit_val),
    .reload(reload), .delta(delta), .ien(ien), .rsten(rsten),
    .cpu_only(cpu_only), .dis(dis), .dbg_halt(dbg_halt),
    .idle_halt(idle_halt)
  );

  wwdt_count #(.CW(CW)) u_count (
    .clk(clk), .rst(rst), .tick_en(tick_en), .idle_in(idle_in),
    .debug_in(debug_in), .restart_req(restart_req), .commit(commit),
    .commit_val(commit_val), .reload(reload), .delta(delta),
    .dis(dis), .dbg_halt(dbg_halt), .idle_halt(idle_halt),
    .uf_fault(uf_fault), .win_fault(win_fault)
  );

  wwdt_fault #(.SW(ST_W)) u_fault (
    .clk(clk), .rst(rst), .uf_fault(uf_fault), .win_fault(win_fault),
    .rd_clear(rd_clear), .ien(ien), .rsten(rsten), .cpu_only(cpu_only),
    .status_q(status_q), .irq_q(irq), .sys_q(sys_rst_req),
    .cpu_q(cpu_rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        ADR_MODE: rdata <= mode_q;
        ADR_STAT: rdata <= {{(REG_W-ST_W){1'b0}}, status_q};
        default:  rdata <= '0;
      endcase
    end
  end

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ien));
  // R8
  dis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    dis |-> !(uf_fault || win_fault));
endmodule

// File: tb/wwdt_top_test.sv
module wwdt_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, idle_in = 1'b0, debug_in = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sys_rst_req, cpu_rst_req;

  int n_chk = 0, n_bad = 0;
  int n_sys = 0, n_cpu = 0;
  logic rd_seen = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t rq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wwdt_top uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .idle_in(idle_in),
    .debug_in(debug_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sys_rst_req(sys_rst_req),
    .cpu_rst_req(cpu_rst_req)
  );

  always @(posedge clk) begin
    rd_seen <= rd_en;
    if (!rst && sys_rst_req) n_sys <= n_sys + 1;
    if (!rst && cpu_rst_req) n_cpu <= n_cpu + 1;
  end

  // monitor: pops expected read data and compares
  initial begin
    forever begin
      @(negedge clk);
      if (rd_seen && rq.size() > 0) begin
        rd_item_t it;
        it = rq.pop_front();
        n_chk++;
        if (rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; idle_in = 0; debug_in = 0; tick_en = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    n_sys = 0; n_cpu = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    rd_item_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    it.exp = exp; it.tag = tag;
    rq.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] RESTART = 32'hA500_0001;

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 sys_rst_req", {31'b0, sys_rst_req}, 32'd0);
    rd(2'd1, 32'h3FFF_2FFF, "R1 mode reset");
    rd(2'd2, 32'h0, "R1 status reset");
    rd(2'd0, 32'h0, "R2 control reads zero");

    // R5 default reload 0xFFF: fault on tick 4096
    ticks(4095);
    settle();
    check("R5 no early underflow", n_sys, 0);
    rd(2'd2, 32'h0, "R5 status before underflow");
    ticks(1);
    settle();
    check("R12 sys pulse on underflow", n_sys, 1);
    check("R12 no cpu pulse", n_cpu, 0);
    rd(2'd2, 32'h1, "R5 underflow status");
    rd(2'd2, 32'h0, "R10 status read clears");

    // R3/R4/R6/R7/R11 : reload 10, delta 4, irq enable
    do_reset();
    wr(2'd1, 32'h0004_100A);
    wr(2'd1, 32'h0000_2FFF);
    rd(2'd1, 32'h0004_100A, "R3 mode locked");
    wr(2'd0, RESTART);                 // counter 10 > 4
    check("R11 irq after window fault", {31'b0, irq}, 32'd1);
    rd(2'd2, 32'h2, "R7 window fault status");
    check("R11 irq low after clear", {31'b0, irq}, 32'd0);
    wr(2'd0, 32'h5A00_0001);           // wrong key
    rd(2'd2, 32'h0, "R6 wrong key ignored");
    ticks(6);                          // counter 4, at delta
    wr(2'd0, RESTART);
    rd(2'd2, 32'h0, "R6 restart at delta accepted");
    ticks(10);
    rd(2'd2, 32'h0, "R5 reload 10 no fault after 10 ticks");
    ticks(1);
    check("R11 irq on underflow", {31'b0, irq}, 32'd1);
    rd(2'd2, 32'h1, "R4 reload from first write, underflow");
    settle();
    check("R12 no pulses with reset disabled", n_sys + n_cpu, 0);

    // R12 processor-only reset, keeps running
    do_reset();
    wr(2'd1, 32'h0005_6005);
    ticks(6);
    settle();
    check("R12 cpu pulse", n_cpu, 1);
    check("R12 sys quiet in cpu mode", n_sys, 0);
    ticks(6);
    settle();
    check("R5 reload after fault, second cpu pulse", n_cpu, 2);
    check("R11 irq stays low without enable", {31'b0, irq}, 32'd0);

    // R8 disable
    do_reset();
    wr(2'd1, 32'h0000_A003);
    wr(2'd0, RESTART);
    ticks(10);
    settle();
    rd(2'd2, 32'h0, "R8 disabled no fault");
    check("R8 disabled no pulses", n_sys + n_cpu, 0);

    // R9 halts
    do_reset();
    wr(2'd1, 32'h2003_2003);
    idle_in = 1'b1;
    ticks(10);
    settle();
    rd(2'd2, 32'h0, "R9 idle halt freezes");
    idle_in = 1'b0;
    debug_in = 1'b1;
    ticks(3);
    settle();
    check("R9 debug without halt bit counts, not yet", n_sys, 0);
    ticks(1);
    settle();
    check("R9 debug without halt bit counts", n_sys, 1);
    rd(2'd2, 32'h1, "R9 underflow after debug");
    debug_in = 1'b0;

    settle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule